// File: doc/BRIEF.md
# Video Sync Control Filter

This block conditions the three video timing controls (horizontal sync, vertical sync and data enable) in the pixel clock domain. The cleaned levels then go on to the frame packer. Each control is first sampled into a short tap line. A configuration input chooses how horizontal sync and data enable are treated. With filtering on, a level must hold for a minimum number of pixel clocks before it reaches the output. With filtering off, every sampled edge is passed, however short the pulse. Vertical sync is never pulse filtered.

After pulse filtering, each signal must also fit a transition budget. The budget counts accepted output transitions over any 130 consecutive pixel clocks. Horizontal sync and data enable may spend two transitions in that span, and vertical sync only one. A transition that would break the budget is held back and a sticky flag for that signal is raised. The held-back transition is issued on the first clock the window admits it, if it is still being requested. Filtered or not, all three signals leave with the same 3-clock latency, so they stay aligned with each other.

Top module: `sync_ctrl_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives all three outputs and all three flags low and forgets all past transitions.
- R2: With `filtEn` low, each output reproduces its input 3 clock edges after the edge that samples it, for any pulse width, including a 1-clock pulse.
- R3: With `filtEn` high, a horizontal sync or data enable level seen on fewer than 3 consecutive sampling edges never reaches the output.
- R4: With `filtEn` high, a horizontal sync or data enable level held for 3 or more sampling edges reaches the output with the same 3-edge latency and the same width.
- R5: Vertical sync is never pulse filtered: with `filtEn` high, a 1-clock vertical sync pulse still raises `vsOut` 3 edges later.
- R6: `hsOut` and `deOut` each make at most 2 transitions in any 130 consecutive clock edges.
- R7: `vsOut` makes at most 1 transition in any 130 consecutive clock edges, so two of its transitions are at least 130 edges apart.
- R8: When a transition would exceed the budget, the output keeps its level and that signal's flag is set on the same edge. The transition is issued on the first edge the window allows, provided it is still requested.
- R9: The flags are sticky. A one-clock `clrViol` pulse clears all of them. A violation on the same edge as the clear leaves its flag set.
- R10: `violFlags` bit 0 belongs to horizontal sync, bit 1 to vertical sync and bit 2 to data enable. A violation on one signal leaves the other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| filtEn | input | 1 | Minimum-pulse filter enable for horizontal sync and data enable |
| clrViol | input | 1 | Write-one-to-clear pulse for all violation flags |
| hsIn | input | 1 | Raw horizontal sync |
| vsIn | input | 1 | Raw vertical sync |
| deIn | input | 1 | Raw data enable |
| hsOut | output | 1 | Conditioned horizontal sync |
| vsOut | output | 1 | Conditioned vertical sync |
| deOut | output | 1 | Conditioned data enable |
| violFlags | output | 3 | Sticky budget violation flags, one per signal |

## Verification
Some properties are checked on every cycle. The spacing between output transitions is measured against the window, which covers both budgets. A flag may only drop after a clear pulse or a reset. A rising flag must come with an unchanged output, and reset must leave everything low. The bench's scenarios are the only way to show the 3-edge latency, the exact pulse widths that survive or vanish as the hold length is swept with filtering on and off, and the 130-edge deferral of a held-back transition. A cycle-level reference model built from the requirements is compared on every clock, which also covers the clear behaviour and which flag bit belongs to which signal.

// File: rtl/sync_filt_pkg.sv
package sync_filt_pkg;
  localparam int NumChan = 3;
  // channel order fixes the flag bit positions
  localparam int ChHs = 0;
  localparam int ChVs = 1;
  localparam int ChDe = 2;

  typedef struct packed {
    logic [NumChan-1:0] take;    // transition admitted this edge
    logic [NumChan-1:0] refuse;  // transition requested but over budget
  } budgetStrobe_t;
endpackage

// File: rtl/sync_filt_datapath.sv
module sync_filt_datapath
  import sync_filt_pkg::*;
#(
  parameter int MinPulse = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               filtEn,
  input  logic               clrViol,
  input  logic [NumChan-1:0] rawIn,
  input  budgetStrobe_t      strobe,
  output logic [NumChan-1:0] wantMove,
  output logic [NumChan-1:0] levelOut,
  output logic [NumChan-1:0] violOut
);
  localparam int TapTop = MinPulse - 1;

  for (genvar ch = 0; ch < NumChan; ch++) begin : g_chan
    logic [MinPulse-1:0] tap;
    logic                cand;
    logic                lvl;
    logic                flg;

    always_ff @(posedge clk) begin
      if (rst) tap <= '0;
      else     tap <= {tap[TapTop-1:0], rawIn[ch]};
    end

    if (ch == ChVs) begin : g_plain
      // vertical sync only passes through the delay line
      assign cand = tap[TapTop];
    end else begin : g_glitch
      always_comb begin
        if (filtEn) begin
          if (&tap)       cand = 1'b1;
          else if (~|tap) cand = 1'b0;
          else            cand = lvl;
        end else begin
          cand = tap[TapTop];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        lvl <= 1'b0;
        flg <= 1'b0;
      end else begin
        if (strobe.take[ch]) lvl <= cand;
        flg <= (flg & ~clrViol) | strobe.refuse[ch];
      end
    end

    assign wantMove[ch] = cand ^ lvl;
    assign levelOut[ch] = lvl;
    assign violOut[ch]  = flg;
  end
endmodule

// File: rtl/sync_filt_budget.sv
module sync_filt_budget
  import sync_filt_pkg::*;
#(
  parameter int Window  = 130,
  parameter int HsLimit = 2,
  parameter int VsLimit = 1,
  parameter int DeLimit = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NumChan-1:0] wantMove,
  output budgetStrobe_t      strobe
);
  // the current edge plus HistW earlier edges form the window
  localparam int HistW = Window - 1;
  localparam int CntW  = $clog2(Window + 1);

  logic [NumChan-1:0] takeVec;
  logic [NumChan-1:0] refuseVec;

  for (genvar ch = 0; ch < NumChan; ch++) begin : g_chan
    localparam int Limit = (ch == ChHs) ? HsLimit :
                           (ch == ChVs) ? VsLimit : DeLimit;
    logic [HistW-1:0] hist;
    logic [CntW-1:0]  used;
    logic             room;
    logic             takeNow;
    logic             ageOut;

    assign room    = used < CntW'(Limit);
    assign takeNow = wantMove[ch] & room;
    assign ageOut  = hist[HistW-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        hist <= '0;
        used <= '0;
      end else begin
        hist <= {hist[HistW-2:0], takeNow};
        used <= used + CntW'(takeNow) - CntW'(ageOut);
      end
    end

    assign takeVec[ch]   = takeNow;
    assign refuseVec[ch] = wantMove[ch] & ~room;
  end

  assign strobe = '{take: takeVec, refuse: refuseVec};
endmodule

// File: rtl/sync_ctrl_filter.sv
module sync_ctrl_filter
  import sync_filt_pkg::*;
#(
  parameter int MIN_PULSE = 3,
  parameter int WINDOW    = 130,
  parameter int HS_LIMIT  = 2,
  parameter int VS_LIMIT  = 1,
  parameter int DE_LIMIT  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       filtEn,
  input  logic       clrViol,
  input  logic       hsIn,
  input  logic       vsIn,
  input  logic       deIn,
  output logic       hsOut,
  output logic       vsOut,
  output logic       deOut,
  output logic [2:0] violFlags
);
  logic [NumChan-1:0] rawVec;
  logic [NumChan-1:0] wantVec;
  logic [NumChan-1:0] levelVec;
  logic [NumChan-1:0] violVec;
  budgetStrobe_t      strobe;

  assign rawVec = {deIn, vsIn, hsIn};

  sync_filt_datapath #(.MinPulse(MIN_PULSE)) u_path (
    .clk(clk), .rst(rst), .filtEn(filtEn), .clrViol(clrViol),
    .rawIn(rawVec), .strobe(strobe),
    .wantMove(wantVec), .levelOut(levelVec), .violOut(violVec)
  );

  sync_filt_budget #(
    .Window(WINDOW), .HsLimit(HS_LIMIT), .VsLimit(VS_LIMIT), .DeLimit(DE_LIMIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wantMove(wantVec), .strobe(strobe)
  );

  assign hsOut     = levelVec[ChHs];
  assign vsOut     = levelVec[ChVs];
  assign deOut     = levelVec[ChDe];
  assign violFlags = violVec;
endmodule

// File: rtl/sync_ctrl_filter_chk.sv
module sync_ctrl_filter_chk #(
  parameter int Window  = 130,
  parameter int HsLimit = 2,
  parameter int VsLimit = 1,
  parameter int DeLimit = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       clrViol,
  input logic [2:0] levels,
  input logic [2:0] viol
);
  localparam int AgeW = $clog2(Window + 1) + 1;

  p_reset_r1: assert property (@(posedge clk) rst |=> (levels == 3'b000 && viol == 3'b000));

  for (genvar c = 0; c < 3; c++) begin : g_mon
    localparam int Limit = (c == 0) ? HsLimit : (c == 1) ? VsLimit : DeLimit;
    logic            prevLvl;
    logic [AgeW-1:0] ageA;
    logic [AgeW-1:0] ageB;
    logic            seenA;
    logic            seenB;
    logic            moved;
    logic [AgeW-1:0] ageRef;
    logic            seenRef;

    assign moved   = levels[c] ^ prevLvl;
    assign ageRef  = (Limit == 1) ? ageA : ageB;
    assign seenRef = (Limit == 1) ? seenA : seenB;

    always_ff @(posedge clk) begin
      if (rst) begin
        prevLvl <= 1'b0;
        ageA    <= '0;
        ageB    <= '0;
        seenA   <= 1'b0;
        seenB   <= 1'b0;
      end else begin
        prevLvl <= levels[c];
        if (moved) begin
          ageB  <= (ageA >= AgeW'(Window)) ? AgeW'(Window) : ageA + 1'b1;
          ageA  <= AgeW'(1);
          seenB <= seenA;
          seenA <= 1'b1;
        end else begin
          ageA <= (ageA >= AgeW'(Window)) ? AgeW'(Window) : ageA + 1'b1;
          ageB <= (ageB >= AgeW'(Window)) ? AgeW'(Window) : ageB + 1'b1;
        end
      end
    end

    // spacing between a transition and the one Limit steps earlier (R6 and R7)
    p_window_r6_r7: assert property (@(posedge clk) disable iff (rst)
      moved |-> (!seenRef || ageRef >= AgeW'(Window)));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(viol[c]) |-> ($past(clrViol) || $past(rst)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(viol[c]) |-> $stable(levels[c]));
  end
endmodule

bind sync_ctrl_filter sync_ctrl_filter_chk #(
  .Window(WINDOW), .HsLimit(HS_LIMIT), .VsLimit(VS_LIMIT), .DeLimit(DE_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .clrViol(clrViol),
  .levels({deOut, vsOut, hsOut}), .viol(violFlags)
);

// File: tb/tb_sync_ctrl_filter.sv
module tb_sync_ctrl_filter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, filtEn = 1'b0, clrViol = 1'b0;
  logic hsIn = 1'b0, vsIn = 1'b0, deIn = 1'b0;
  logic hsOut, vsOut, deOut;
  logic [2:0] violFlags;
  wire  [2:0] dutLv = {deOut, vsOut, hsOut};

  sync_ctrl_filter dut (
    .clk(clk), .rst(rst), .filtEn(filtEn), .clrViol(clrViol),
    .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut), .violFlags(violFlags)
  );

  int total = 0, bad = 0, cyc = 0;
  string phase = "R1";

  // reference model, written from the requirements
  logic [2:0] mTap [3];
  logic       mOut [3];
  logic       mFlag[3];
  int         accT [3][2];
  int         lims [3] = '{2, 1, 2};
  int         rises[3];
  int         hiCnt[3];
  logic       prevO[3];

  task automatic chk(input string tag, input int got, input int expv);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, expv);
    end
  endtask

  always @(posedge clk) begin
    logic [2:0] rawV;
    logic cand;
    int n;
    rawV = {deIn, vsIn, hsIn};
    cyc++;
    for (int c = 0; c < 3; c++) begin
      if (rst) begin
        mTap[c] = 3'b000; mOut[c] = 1'b0; mFlag[c] = 1'b0;
        accT[c][0] = -1000; accT[c][1] = -1000;
      end else begin
        if (c != 1 && filtEn) begin
          if (mTap[c] == 3'b111)      cand = 1'b1;
          else if (mTap[c] == 3'b000) cand = 1'b0;
          else                        cand = mOut[c];
        end else begin
          cand = mTap[c][2];
        end
        mFlag[c] = mFlag[c] & ~clrViol;
        if (cand != mOut[c]) begin
          n = 0;
          for (int k = 0; k < 2; k++) if (cyc - accT[c][k] < 130) n++;
          if (n < lims[c]) begin
            accT[c][1] = accT[c][0];
            accT[c][0] = cyc;
            mOut[c] = cand;
          end else begin
            mFlag[c] = 1'b1;
          end
        end
        mTap[c] = {mTap[c][1:0], rawV[c]};
      end
    end
  end

  always @(posedge clk) begin
    #2;
    for (int c = 0; c < 3; c++) begin
      if (!rst) begin
        chk($sformatf("%s model level ch%0d", phase, c), dutLv[c], mOut[c]);
        chk($sformatf("%s model flag ch%0d", phase, c), violFlags[c], mFlag[c]);
        if (dutLv[c] && !prevO[c]) rises[c]++;
        if (dutLv[c]) hiCnt[c]++;
      end
      prevO[c] = dutLv[c];
    end
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearCounts();
    for (int c = 0; c < 3; c++) begin
      rises[c] = 0;
      hiCnt[c] = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog R1 got=expired exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    chk("R1 reset levels", dutLv, 0);
    chk("R1 reset flags", violFlags, 0);
    rst = 1'b0;

    // R2: aligned 3-edge latency, filter off
    phase = "R2";
    ticks(5);
    hsIn = 1; vsIn = 1; deIn = 1;
    ticks(3);
    chk("R2 before latency", dutLv, 0);
    ticks(1);
    chk("R2 after latency", dutLv, 7);
    ticks(200);
    hsIn = 0; vsIn = 0; deIn = 0;
    ticks(200);

    // R2/R3/R4 sweep over pulse width, filter off then on
    for (int en = 0; en < 2; en++) begin
      for (int w = 1; w <= 6; w++) begin
        int pass;
        filtEn = en[0];
        phase = (en == 0) ? "R2" : ((w < 3) ? "R3" : "R4");
        pass = (en == 0 || w >= 3) ? 1 : 0;
        clearCounts();
        hsIn = 1; deIn = 1;
        ticks(w);
        hsIn = 0; deIn = 0;
        ticks(160);
        chk($sformatf("%s hs pulses w=%0d", phase, w), rises[0], pass);
        chk($sformatf("%s hs width w=%0d", phase, w), hiCnt[0], pass * w);
        chk($sformatf("%s de pulses w=%0d", phase, w), rises[2], pass);
        chk($sformatf("%s de width w=%0d", phase, w), hiCnt[2], pass * w);
      end
    end

    // R5/R7/R8: one-clock vertical sync pulse with filter on
    phase = "R5";
    filtEn = 1;
    clearCounts();
    vsIn = 1;
    ticks(1);
    vsIn = 0;
    ticks(60);
    chk("R5 vs pulse passed", rises[1], 1);
    chk("R8 vs held high", vsOut, 1);
    chk("R8 R10 vs flag only", violFlags, 3'b010);
    ticks(150);
    chk("R7 vs high span", hiCnt[1], 130);
    chk("R7 vs fell later", vsOut, 0);

    phase = "R9";
    clrViol = 1;
    ticks(1);
    clrViol = 0;
    chk("R9 clear", violFlags, 0);

    // R6/R8: third hs transition inside the window, filter off
    phase = "R6";
    filtEn = 0;
    ticks(5);
    clearCounts();
    hsIn = 1; ticks(5);
    hsIn = 0; ticks(5);
    hsIn = 1; ticks(60);
    chk("R8 hs held low", hsOut, 0);
    chk("R8 R10 hs flag only", violFlags, 3'b001);
    ticks(110);
    chk("R6 hs deferred rise", hsOut, 1);
    chk("R6 hs rises", rises[0], 2);
    chk("R9 hs flag sticky", violFlags, 3'b001);
    phase = "R9";
    clrViol = 1;
    ticks(1);
    clrViol = 0;
    chk("R9 clear hs", violFlags, 0);
    hsIn = 0;
    ticks(200);

    // R6/R10: data enable budget with filter on
    phase = "R10";
    filtEn = 1;
    clearCounts();
    deIn = 1; ticks(4);
    deIn = 0; ticks(4);
    deIn = 1; ticks(40);
    chk("R10 de flag only", violFlags, 3'b100);
    chk("R8 de held low", deOut, 0);
    ticks(150);
    chk("R6 de deferred rise", deOut, 1);
    chk("R6 de rises", rises[2], 2);
    deIn = 0;
    ticks(200);

    // R1: reset in the middle of activity
    phase = "R1";
    hsIn = 1; vsIn = 1;
    ticks(10);
    rst = 1;
    ticks(2);
    chk("R1 mid reset levels", dutLv, 0);
    chk("R1 mid reset flags", violFlags, 0);
    hsIn = 0; vsIn = 0;
    rst = 0;
    ticks(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule